// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Binary Counter Stage

This block is one stage of a synchronous up-counter with a parallel preset. On each rising clock edge it does exactly one of four things, in fixed priority: clear to zero, load a parallel data word, advance by one, or hold. Clear and load are active-low; the two enables are active-high. Counting needs both enables. The carry output depends on only one of them, the chain enable.

Stages chain into wider counters. All stages share the clock, clear, load and count enable. The lowest stage takes the external chain enable. Each higher stage takes its chain enable from the carry output of the stage below it. The carry output is combinational from the current count and the chain enable. A whole chain therefore steps in the same clock edge, with no ripple between flip-flops. The count width is a parameter and defaults to 4 bits.

Top module: `sync_count_stage`

## Requirements
- R1: When `clear_n` is 0 at a rising clock edge, `count` becomes 0 after that edge, whatever `load_n`, `cnt_en` and `chain_en` are.
- R2: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din`, whatever the two enables are.
- R3: When `clear_n` and `load_n` are both 1 and `cnt_en` and `chain_en` are both 1, `count` increases by exactly one at the edge.
- R4: When `clear_n` and `load_n` are both 1 and either enable is 0, `count` keeps its value across the edge.
- R5: Counting from the all-ones value (15 at the default width) gives 0, so a free-running stage cycles through 2^W states.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `count` is all ones, whatever `cnt_en` is. It follows `chain_en` within the same cycle, with no clock edge in between.
- R7: Clear, load and count act only at a rising clock edge. A change of `clear_n` or `load_n` between edges leaves `count` unchanged until the next edge.
- R8: Two stages, with the upper stage's `chain_en` driven by the lower stage's `carry_out` and all other controls shared, act as one 2W-bit counter. This includes the wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all stages of a chain |
| chain_en | input | 1 | Count enable that also qualifies the carry output |
| din | input | W | Parallel preset word |
| count | output | W | Current count |
| carry_out | output | 1 | High when chain_en is high and count is all ones |

## Verification
The bench applies clear and load in the same cycle. A stage that ranked load above clear would end up at the preset word instead of zero. It also loads while both enables are high, where a stage that ranked counting first would show the old count plus one. It parks the count at all ones with the count enable low. A carry gated by both enables would then stay low and stall a chain. With the chain enable low there, a carry that skipped that gate would stay high. Finally, two stages run through their 8-bit wrap. An upper stage that stepped on its own, or that missed the lower carry, breaks the combined value at every multiple of 16.

// File: rtl/sync_count_pkg.sv
package sync_count_pkg;

  // Action taken by a stage at the next rising edge, in priority order.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } stage_op_e;

endpackage

// File: rtl/sync_count_ctrl.sv
module sync_count_ctrl
  import sync_count_pkg::*;
(
  input  logic      clear_n,
  input  logic      load_n,
  input  logic      cnt_en,
  input  logic      chain_en,
  output stage_op_e op
);

  // Fixed priority: clear, then load, then count, else hold.
  always_comb begin
    op = OP_HOLD;
    if (!clear_n) begin
      op = OP_CLEAR;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (cnt_en && chain_en) begin
      op = OP_INC;
    end
  end

endmodule

// File: rtl/sync_count_next.sv
module sync_count_next
  import sync_count_pkg::*;
#(
  parameter int W = 4
) (
  input  stage_op_e      op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   nxt,
  output logic           upd
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    unique case (op)
      OP_CLEAR: begin
        nxt = ZERO;
        upd = 1'b1;
      end
      OP_LOAD: begin
        nxt = din;
        upd = 1'b1;
      end
      OP_INC: begin
        nxt = cur + ONE;
        upd = 1'b1;
      end
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sync_count_carry.sv
module sync_count_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         chain_en,
  output logic         carry_out
);

  // AND chain over the count bits, seeded with the chain enable.
  logic [W:0] all_ones;

  assign all_ones[0] = chain_en;

  for (genvar i = 0; i < W; i++) begin : g_and
    assign all_ones[i+1] = all_ones[i] & cur[i];
  end

  assign carry_out = all_ones[W];

endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
  import sync_count_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] count,
  output logic         carry_out
);

  stage_op_e    op;
  logic [W-1:0] count_q;
  logic [W-1:0] count_d;
  logic         count_we;

  sync_count_ctrl u_ctrl (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  sync_count_next #(.W(W)) u_next (
    .op  (op),
    .cur (count_q),
    .din (din),
    .nxt (count_d),
    .upd (count_we)
  );

  sync_count_carry #(.W(W)) u_carry (
    .cur       (count_q),
    .chain_en  (chain_en),
    .carry_out (carry_out)
  );

  // State register with an explicit clock enable.
  always_ff @(posedge clk) begin
    if (count_we) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/sync_count_stage_chk.sv
module sync_count_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load_n,
  input logic         cnt_en,
  input logic         chain_en,
  input logic [W-1:0] din,
  input logic [W-1:0] count,
  input logic         carry_out
);

  localparam logic [W-1:0] ONE = W'(1);

  // The count is unknown until the first clear; checks start after it.
  bit armed = 1'b0;
  always @(posedge clk) begin
    if (!clear_n) armed <= 1'b1;
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> count == '0);

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && !load_n) |=> count == $past(din));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && cnt_en && chain_en) |=> count == $past(count) + ONE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && !(cnt_en && chain_en)) |=> $stable(count));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && cnt_en && carry_out) |=> count == '0);

  p_carry_gate_r6: assert property (@(posedge clk) disable iff (!armed)
    !chain_en |-> !carry_out);

endmodule

bind sync_count_stage sync_count_stage_chk #(.W(W)) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .chain_en  (chain_en),
  .din       (din),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/sync_count_stage_tb.sv
`timescale 1ns/1ps
module sync_count_stage_tb;

  localparam int W = 4;
  localparam logic [W-1:0] MAXV = '1;

  typedef struct {
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         clear_n, load_n, cnt_en, chain_en;
  logic [W-1:0] din_lo, din_hi;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         co_lo, co_hi;

  int checks = 0;
  int fails  = 0;

  exp_t         sb_q[$];
  logic [W-1:0] m_lo, m_hi;

  always #2.5 clk = ~clk;

  sync_count_stage #(.W(W)) u_dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .din(din_lo), .count(cnt_lo), .carry_out(co_lo)
  );

  // Upper stage of the 2W-bit chain.
  sync_count_stage #(.W(W)) u_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(co_lo), .din(din_hi), .count(cnt_hi), .carry_out(co_hi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_next(input logic [W-1:0] cur, input logic en2,
                                               input logic [W-1:0] d);
    if (!clear_n) return '0;
    if (!load_n) return d;
    if (cnt_en && en2) return cur + W'(1);
    return cur;
  endfunction

  // Driver: applies one cycle of stimulus, checks combinational carry and
  // between-edge stability, then queues the expected post-edge counts.
  task automatic step(input logic c_n, input logic l_n, input logic ep, input logic et,
                      input logic [W-1:0] dl, input logic [W-1:0] dh, input string tag);
    logic lo_carry;
    exp_t e;
    @(negedge clk);
    clear_n = c_n; load_n = l_n; cnt_en = ep; chain_en = et;
    din_lo = dl; din_hi = dh;
    #1;
    lo_carry = et && (m_lo == MAXV);
    if (m_lo !== 'x) begin
      check(co_lo === lo_carry, "R6 lower carry", int'(co_lo), int'(lo_carry));
      check(co_hi === (lo_carry && m_hi == MAXV), "R6 upper carry", int'(co_hi),
            int'(lo_carry && m_hi == MAXV));
      check(cnt_lo === m_lo, "R7 count stable before edge", int'(cnt_lo), int'(m_lo));
    end
    e.lo  = model_next(m_lo, et, dl);
    e.hi  = model_next(m_hi, lo_carry, dh);
    e.tag = tag;
    m_lo  = e.lo;
    m_hi  = e.hi;
    sb_q.push_back(e);
  endtask

  // Monitor: compares counts just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(cnt_lo === e.lo, {e.tag, " lower"}, int'(cnt_lo), int'(e.lo));
        check(cnt_hi === e.hi, {e.tag, " upper"}, int'(cnt_hi), int'(e.hi));
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_lo = 'x; m_hi = 'x;
    clear_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    din_lo = '0; din_hi = '0;

    // Reset state through clear, with every other control active (R1).
    step(0, 0, 1, 1, 4'h9, 4'h6, "R1 clear from unknown");
    step(1, 1, 0, 0, 4'h0, 4'h0, "R4 idle after clear");

    // Free run through more than one lap of the lower stage (R3, R5, R8).
    for (int i = 0; i < 20; i++) step(1, 1, 1, 1, 4'h0, 4'h0, "R3 R5 free run");

    // Hold with either enable low (R4).
    step(1, 1, 0, 1, 4'h0, 4'h0, "R4 hold cnt_en low");
    step(1, 1, 1, 0, 4'h0, 4'h0, "R4 hold chain_en low");
    step(1, 1, 0, 0, 4'h0, 4'h0, "R4 hold both low");

    // Park at all ones with the count enable low: carry must still rise (R6).
    step(1, 0, 0, 1, MAXV, 4'h2, "R2 load all ones");
    step(1, 1, 0, 1, 4'h0, 4'h0, "R6 carry with cnt_en low");
    step(1, 1, 0, 0, 4'h0, 4'h0, "R6 carry gated by chain_en");

    // Load while counting is enabled: load wins (R2).
    step(1, 0, 1, 1, 4'h5, 4'hA, "R2 load over count");
    step(1, 1, 1, 1, 4'h0, 4'h0, "R3 count after load");

    // Load and clear together: clear wins (R1).
    step(0, 0, 1, 1, 4'hC, 4'h3, "R1 clear over load");

    // Preset the chain near its top and run through the 8-bit wrap (R8).
    step(1, 0, 0, 0, 4'hD, 4'hF, "R8 chain preset");
    for (int i = 0; i < 40; i++) step(1, 1, 1, 1, 4'h0, 4'h0, "R8 chain wrap");
    step(1, 0, 1, 1, 4'hE, 4'h7, "R8 chain preset mid");
    for (int i = 0; i < 300; i++) step(1, 1, 1, 1, 4'h0, 4'h0, "R8 chain long run");

    // Clear between edges must wait for the edge (R7 checked in the next step).
    step(0, 1, 0, 0, 4'h0, 4'h0, "R1 R7 late clear");
    step(1, 1, 0, 0, 4'h0, 4'h0, "R4 idle at end");

    @(posedge clk); #2;
    @(posedge clk); #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule